// File: doc/BRIEF.md
# Per-Interface Demand Predictor and Proportional Slot Allocator

This block sits beside a token-passing wireless medium-access controller. At every token-period boundary it takes one measured bandwidth demand per wireless interface. For each interface it keeps the full demand history as a cumulative sum and a shared period count. From these it forms a prediction for the next period by blending the long-run average with the demand just reported. The running average follows the steady traffic level, and the last-period term follows sudden shifts.

The block then splits a fixed budget of data-flit slots among the interfaces in proportion to their predictions. All divisions share one iterative divider, so a full update takes several hundred cycles. This is short next to a token period. Shares are rounded down. The slots lost to rounding are handed back one at a time, starting with the interface that has the largest prediction. If every prediction is zero, the budget is split evenly. The resulting vector of allocations is meant to be packed into a control flit and broadcast, and it governs the period that follows the report.

Top module: `demand_slot_alloc`

## Requirements
- R1: After reset, `busy`, `donePulse` and `allocValid` are low and every allocation field is zero.
- R2: A `reportValid` pulse seen while `busy` is low is accepted, and `busy` is high in the following cycle.
- R3: Interface i's demand is `demandVec[i*8 +: 8]`. For each accepted report, the average is floor(sum of all accepted demands of that interface / number of accepted reports), with the current report included. The prediction is floor((average + current demand) / 2).
- R4: Each interface first receives floor(prediction × 96 / sum of all predictions) slots.
- R5: The slots left over after R4 are given out one per interface, in descending order of prediction. Among equal predictions, the lower interface index goes first.
- R6: When every prediction is zero, every interface is treated as having prediction 1. This gives 96/12 slots each, with any remainder going to the lowest indices.
- R7: Whenever `allocValid` is high, the allocations sum to exactly 96.
- R8: `donePulse` lasts one cycle, and `allocValid` is high during it. `allocValid` and the allocations stay unchanged until the next accepted report. Interface i's allocation is `allocVec[i*7 +: 7]`.
- R9: A `reportValid` pulse while `busy` is high is ignored. It changes neither the history nor the allocation that results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reportValid | input | 1 | Token-period boundary strobe carrying new demands |
| demandVec | input | 96 | Measured demand per interface, 8 bits each |
| busy | output | 1 | Computation in progress; reports are not accepted |
| donePulse | output | 1 | One-cycle strobe when the allocations are complete |
| allocValid | output | 1 | Allocations are complete and stable |
| allocVec | output | 84 | Slot allocation per interface, 7 bits each |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that `reportValid` and `demandVec` change only between edges, and that the history count never reaches its saturation limit. The stimulus keeps within these limits: it drives inputs on the falling edge and sends only a handful of reports. It also drives the ignored-report pulses only while `busy` is high, so that the rejection path is exercised and does not disturb accepted traffic.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AVG_GO,
    ST_AVG_WAIT,
    ST_SHR_GO,
    ST_SHR_WAIT,
    ST_FIX,
    ST_DONE
  } ctrlState_t;

  typedef struct packed {
    logic capture;   // latch new demands into history
    logic divStart;  // launch divider
    logic divSel;    // 0: average phase, 1: share phase
    logic storeQ;    // write divider quotient at current index
    logic giveOne;   // hand one leftover slot out
  } ctrlStrobes_t;

endpackage

// File: rtl/dmd_divider.sv
module dmd_divider #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remR, denR, quoR;
  logic [CW-1:0] cntR;
  logic          runR;
  logic [W:0]    remShift;
  logic          ge;
  logic [W-1:0]  remSub;

  always_comb begin
    remShift = {remR, quoR[W-1]};
    ge       = remShift >= {1'b0, denR};
    remSub   = remShift[W-1:0] - denR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      denR <= '0;
      quoR <= '0;
      cntR <= '0;
      runR <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      remR <= '0;
      denR <= den;
      quoR <= num;
      cntR <= CW'(W);
      runR <= 1'b1;
      done <= 1'b0;
    end else if (runR) begin
      remR <= ge ? remSub : remShift[W-1:0];
      quoR <= {quoR[W-2:0], ge};
      cntR <= cntR - 1'b1;
      if (cntR == CW'(1)) begin
        runR <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = quoR;
endmodule

// File: rtl/dmd_datapath.sv
module dmd_datapath
  import dmd_pkg::*;
#(
  parameter int NUM_IF      = 12,
  parameter int DW          = 8,
  parameter int CNT_W       = 16,
  parameter int TOTAL_SLOTS = 96,
  parameter int IDX_W       = 4,
  parameter int SLOT_W      = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strb,
  input  logic [IDX_W-1:0]         idx,
  input  logic [NUM_IF*DW-1:0]     demandVec,
  output logic                     divDone,
  output logic                     leftoverZero,
  output logic [NUM_IF*SLOT_W-1:0] allocVec
);
  localparam int SUM_W = DW + CNT_W;
  localparam int DIV_W = SUM_W;
  localparam int TOT_W = DW + $clog2(NUM_IF + 1);
  localparam int SS_W  = SLOT_W + $clog2(NUM_IF + 1);

  logic [SUM_W-1:0]  sumR   [NUM_IF];
  logic [DW-1:0]     lastR  [NUM_IF];
  logic [DW-1:0]     predR  [NUM_IF];
  logic [DW-1:0]     predEff[NUM_IF];
  logic [SLOT_W-1:0] shareR [NUM_IF];
  logic [CNT_W-1:0]  cntR;
  logic [NUM_IF-1:0] givenR;

  logic [TOT_W-1:0]  totalSum, totalEff;
  logic [SS_W-1:0]   shareSum;
  logic [IDX_W-1:0]  bestIdx;
  logic [DW-1:0]     bestVal;
  logic              bestFound;
  logic [DIV_W-1:0]  divNum, divDen, divQ;
  logic [DW-1:0]     avgSat;
  logic [SLOT_W-1:0] shareSat;
  logic [DW:0]       avgPlusLast;

  // prediction total; an all-zero set falls back to equal weights
  always_comb begin
    totalSum = '0;
    for (int i = 0; i < NUM_IF; i++) totalSum = totalSum + TOT_W'(predR[i]);
    totalEff = (totalSum == '0) ? TOT_W'(NUM_IF) : totalSum;
    for (int i = 0; i < NUM_IF; i++)
      predEff[i] = (totalSum == '0) ? DW'(1) : predR[i];
  end

  always_comb begin
    shareSum = '0;
    for (int i = 0; i < NUM_IF; i++) shareSum = shareSum + SS_W'(shareR[i]);
    leftoverZero = (shareSum == SS_W'(TOTAL_SLOTS));
  end

  // largest remaining prediction, lowest index wins ties
  always_comb begin
    bestIdx   = '0;
    bestVal   = '0;
    bestFound = 1'b0;
    for (int i = 0; i < NUM_IF; i++) begin
      if (!givenR[i] && (!bestFound || predEff[i] > bestVal)) begin
        bestIdx   = IDX_W'(i);
        bestVal   = predEff[i];
        bestFound = 1'b1;
      end
    end
  end

  always_comb begin
    if (strb.divSel) begin
      divNum = DIV_W'(predEff[idx]) * DIV_W'(TOTAL_SLOTS);
      divDen = DIV_W'(totalEff);
    end else begin
      divNum = DIV_W'(sumR[idx]);
      divDen = DIV_W'(cntR);
    end
  end

  dmd_divider #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rstN  (rstN),
    .start (strb.divStart),
    .num   (divNum),
    .den   (divDen),
    .quo   (divQ),
    .done  (divDone)
  );

  always_comb begin
    avgSat      = (divQ > DIV_W'({DW{1'b1}})) ? {DW{1'b1}} : divQ[DW-1:0];
    shareSat    = (divQ > DIV_W'(TOTAL_SLOTS)) ? SLOT_W'(TOTAL_SLOTS) : divQ[SLOT_W-1:0];
    avgPlusLast = {1'b0, avgSat} + {1'b0, lastR[idx]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntR   <= '0;
      givenR <= '0;
      for (int i = 0; i < NUM_IF; i++) begin
        sumR[i]   <= '0;
        lastR[i]  <= '0;
        predR[i]  <= '0;
        shareR[i] <= '0;
      end
    end else begin
      if (strb.capture) begin
        givenR <= '0;
        if (cntR != {CNT_W{1'b1}}) cntR <= cntR + 1'b1;
        for (int i = 0; i < NUM_IF; i++) begin
          lastR[i]  <= demandVec[i*DW +: DW];
          shareR[i] <= '0;
          if (cntR != {CNT_W{1'b1}})
            sumR[i] <= sumR[i] + SUM_W'(demandVec[i*DW +: DW]);
        end
      end
      if (strb.storeQ && !strb.divSel) predR[idx]  <= avgPlusLast[DW:1];
      if (strb.storeQ &&  strb.divSel) shareR[idx] <= shareSat;
      if (strb.giveOne) begin
        shareR[bestIdx] <= shareR[bestIdx] + 1'b1;
        givenR[bestIdx] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_IF; g++) begin : g_pack
    assign allocVec[g*SLOT_W +: SLOT_W] = shareR[g];
  end
endmodule

// File: rtl/dmd_control.sv
module dmd_control
  import dmd_pkg::*;
#(
  parameter int NUM_IF = 12,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reportValid,
  input  logic             divDone,
  input  logic             leftoverZero,
  output ctrlStrobes_t     strb,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             donePulse,
  output logic             allocValid
);
  ctrlState_t state;
  logic       lastIdx;

  assign lastIdx = (idx == IDX_W'(NUM_IF - 1));

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE:     strb.capture = reportValid;
      ST_AVG_GO:   strb.divStart = 1'b1;
      ST_AVG_WAIT: strb.storeQ = divDone;
      ST_SHR_GO:   begin strb.divStart = 1'b1; strb.divSel = 1'b1; end
      ST_SHR_WAIT: begin strb.storeQ = divDone; strb.divSel = 1'b1; end
      ST_FIX:      strb.giveOne = !leftoverZero;
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      idx        <= '0;
      allocValid <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reportValid) begin
          state      <= ST_AVG_GO;
          idx        <= '0;
          allocValid <= 1'b0;
        end
        ST_AVG_GO: state <= ST_AVG_WAIT;
        ST_AVG_WAIT: if (divDone) begin
          idx   <= lastIdx ? '0 : idx + 1'b1;
          state <= lastIdx ? ST_SHR_GO : ST_AVG_GO;
        end
        ST_SHR_GO: state <= ST_SHR_WAIT;
        ST_SHR_WAIT: if (divDone) begin
          idx   <= lastIdx ? '0 : idx + 1'b1;
          state <= lastIdx ? ST_FIX : ST_SHR_GO;
        end
        ST_FIX: if (leftoverZero) begin
          state      <= ST_DONE;
          allocValid <= 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign donePulse = (state == ST_DONE);
endmodule

// File: rtl/demand_slot_alloc.sv
module demand_slot_alloc
  import dmd_pkg::*;
#(
  parameter int NUM_IF      = 12,
  parameter int DW          = 8,
  parameter int CNT_W       = 16,
  parameter int TOTAL_SLOTS = 96,
  localparam int SLOT_W     = $clog2(TOTAL_SLOTS + 1),
  localparam int IDX_W      = (NUM_IF > 1) ? $clog2(NUM_IF) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reportValid,
  input  logic [NUM_IF*DW-1:0]     demandVec,
  output logic                     busy,
  output logic                     donePulse,
  output logic                     allocValid,
  output logic [NUM_IF*SLOT_W-1:0] allocVec
);
  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] idx;
  logic             divDone, leftoverZero;

  dmd_control #(.NUM_IF(NUM_IF), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reportValid  (reportValid),
    .divDone      (divDone),
    .leftoverZero (leftoverZero),
    .strb         (strb),
    .idx          (idx),
    .busy         (busy),
    .donePulse    (donePulse),
    .allocValid   (allocValid)
  );

  dmd_datapath #(
    .NUM_IF(NUM_IF), .DW(DW), .CNT_W(CNT_W), .TOTAL_SLOTS(TOTAL_SLOTS),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .idx          (idx),
    .demandVec    (demandVec),
    .divDone      (divDone),
    .leftoverZero (leftoverZero),
    .allocVec     (allocVec)
  );
endmodule

// File: rtl/dmd_checker.sv
module dmd_checker #(
  parameter int NUM_IF      = 12,
  parameter int SLOT_W      = 7,
  parameter int TOTAL_SLOTS = 96
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     reportValid,
  input logic                     busy,
  input logic                     donePulse,
  input logic                     allocValid,
  input logic [NUM_IF*SLOT_W-1:0] allocVec
);
  int allocTotal;

  always_comb begin
    allocTotal = 0;
    for (int i = 0; i < NUM_IF; i++) allocTotal += int'(allocVec[i*SLOT_W +: SLOT_W]);
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reportValid) |=> busy);                                    // R2
  AST_BUDGET_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |-> (allocTotal == TOTAL_SLOTS));                         // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);                                           // R8
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> allocValid);                                           // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !busy && !reportValid) |=> (allocValid && $stable(allocVec))); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !donePulse) |=> busy);                                      // R9
endmodule

bind demand_slot_alloc dmd_checker #(
  .NUM_IF(NUM_IF), .SLOT_W(SLOT_W), .TOTAL_SLOTS(TOTAL_SLOTS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reportValid (reportValid),
  .busy        (busy),
  .donePulse   (donePulse),
  .allocValid  (allocValid),
  .allocVec    (allocVec)
);

// File: tb/tb_demand_slot_alloc.sv
module tb_demand_slot_alloc;
  localparam int N = 12;
  localparam int DW = 8;
  localparam int TOT = 96;
  localparam int SW = 7;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reportValid = 1'b0;
  logic [N*DW-1:0]   demandVec = '0;
  logic              busy, donePulse, allocValid;
  logic [N*SW-1:0]   allocVec;

  int checks = 0;
  int failures = 0;
  int doneCount = 0;
  bit finished = 1'b0;

  int mSum[N];
  int mCnt = 0;
  logic [N*SW-1:0] expQ[$];
  logic [N*SW-1:0] lastExp = '0;

  always #2.5 clk = ~clk;

  demand_slot_alloc dut (
    .clk(clk), .rstN(rstN), .reportValid(reportValid), .demandVec(demandVec),
    .busy(busy), .donePulse(donePulse), .allocValid(allocValid), .allocVec(allocVec)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N*SW-1:0] modelUpdate(input logic [N*DW-1:0] d);
    int pred[N], eff[N], share[N];
    bit given[N];
    int total, teff, used, left;
    logic [N*SW-1:0] v;
    mCnt++;
    total = 0;
    for (int i = 0; i < N; i++) begin
      int cur;
      cur = int'(d[i*DW +: DW]);
      mSum[i] += cur;
      pred[i] = ((mSum[i] / mCnt) + cur) / 2;   // R3
      total += pred[i];
    end
    teff = (total == 0) ? N : total;            // R6
    used = 0;
    for (int i = 0; i < N; i++) begin
      eff[i] = (total == 0) ? 1 : pred[i];
      share[i] = eff[i] * TOT / teff;           // R4
      used += share[i];
      given[i] = 1'b0;
    end
    left = TOT - used;
    for (int k = 0; k < left; k++) begin        // R5
      int b;
      b = -1;
      for (int i = 0; i < N; i++)
        if (!given[i] && (b < 0 || eff[i] > eff[b])) b = i;
      share[b]++;
      given[b] = 1'b1;
    end
    for (int i = 0; i < N; i++) v[i*SW +: SW] = SW'(share[i]);
    return v;
  endfunction

  task automatic sendReport(input logic [N*DW-1:0] d, input bit poke);
    int startDone;
    while (busy) @(negedge clk);
    startDone = doneCount;
    demandVec = d;
    reportValid = 1'b1;
    expQ.push_back(modelUpdate(d));
    @(negedge clk);
    reportValid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    if (poke) begin
      // R9: pulses during busy must not enter the history
      for (int k = 0; k < 3; k++) begin
        demandVec = {N{8'hC3}};
        reportValid = 1'b1;
        @(negedge clk);
        reportValid = 1'b0;
        @(negedge clk);
      end
    end
    while (doneCount == startDone) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && donePulse) begin
      logic [N*SW-1:0] e;
      int s;
      doneCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        e = expQ.pop_front();
        lastExp = e;
        s = 0;
        for (int i = 0; i < N; i++) begin
          s += int'(allocVec[i*SW +: SW]);
          check(allocVec[i*SW +: SW] == e[i*SW +: SW], "R3/R4/R5/R6/R9 alloc",
                int'(allocVec[i*SW +: SW]), int'(e[i*SW +: SW]));
        end
        check(s == TOT, "R7 budget", s, TOT);
        check(allocValid == 1'b1, "R8 valid at done", int'(allocValid), 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N*DW-1:0] d;
    for (int i = 0; i < N; i++) mSum[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(donePulse == 1'b0, "R1 done", int'(donePulse), 0);
    check(allocValid == 1'b0, "R1 valid", int'(allocValid), 0);
    check(allocVec == '0, "R1 alloc", 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    sendReport('0, 1'b0);                         // R6 all zero
    sendReport({N{8'd10}}, 1'b0);                 // uniform
    for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'(i * 20);
    sendReport(d, 1'b0);                          // ramp
    for (int i = 0; i < N; i++) d[i*DW +: DW] = (i == 5) ? 8'd255 : 8'd0;
    sendReport(d, 1'b1);                          // spike, with ignored pokes (R9)
    for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'((i % 3) * 37 + 1);
    sendReport(d, 1'b0);                          // ties across indices (R5)
    for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'(255 - i * 7);
    sendReport(d, 1'b1);                          // descending
    for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'((i * 53) % 97);
    sendReport(d, 1'b0);                          // scattered

    // R8 hold: allocations stay put while idle
    repeat (20) @(negedge clk);
    check(allocValid == 1'b1, "R8 valid held", int'(allocValid), 1);
    check(allocVec == lastExp, "R8 alloc held", int'(allocVec[SW-1:0]), int'(lastExp[SW-1:0]));
    check(expQ.size() == 0, "R8 queue drained", expQ.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule